// File: doc/BRIEF.md
# Synchronous FIFO with status flags

This block is a single-clock first-in first-out buffer. A producer presents a word on `din` with `wr_en`, and a consumer pulls words with `rd_en`. The buffer accepts a write only when it is not full and a read only when it is not empty. A request that cannot be served is dropped and leaves the stored words as they were. Read data comes from one output register, so a word shows up on `dout` in the cycle after its read is accepted, together with `data_valid`.

Status outputs let the neighbours pace themselves. `full` and `empty` mark the two ends of the buffer. `almost_full` and `almost_empty` mark one step before each end. Two flags compare the occupancy against threshold parameters. Three one-cycle pulses report, one cycle late, whether a write was accepted, whether a write was refused, and whether a read was refused. The occupancy is also visible as a count.

The depth is a power of two. The reset is synchronous and active low. A parameter chooses the value that the full-side flags take during reset, and another chooses the value that `dout` takes during reset.

Top module: `sfifo_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads this state: `empty`=1, `almost_empty`=0, `prog_empty`=1, `occupancy`=0, and `overflow`, `underflow`, `wr_ack` and `data_valid` all 0. `full`, `almost_full` and `prog_full` take FULL_RST_VAL (0 by default). `dout` takes DOUT_RST_VAL (0 by default).
- R2: A write is accepted at a rising edge exactly when `wr_en`=1 and `full`=0 in that cycle. Accepted words leave the buffer in the order they were written. This holds even when a read is accepted in the same cycle.
- R3: A write requested while `full`=1 leaves the stored words and the occupancy unchanged, and `overflow` is 1 in the following cycle only.
- R4: A read requested while `empty`=1 changes no state, and `underflow` is 1 in the following cycle only.
- R5: `wr_ack` is 1 in the cycle after an accepted write, and 0 otherwise.
- R6: After an accepted read, `dout` holds the oldest stored word and `data_valid` is 1, both in the next cycle. In every other cycle `data_valid` is 0 and `dout` keeps its previous value.
- R7: `occupancy` (log2(DEPTH)+1 bits) equals the number of stored words, one cycle after the operations that changed it. An accepted read and an accepted write in the same cycle leave it unchanged.
- R8: `full` is 1 exactly when occupancy equals DEPTH. `empty` is 1 exactly when occupancy is 0. The two are never 1 together.
- R9: `almost_full` is 1 exactly when occupancy is DEPTH-1. `almost_empty` is 1 exactly when occupancy is 1.
- R10: `prog_full` is 1 when occupancy is at least PFULL_TH. `prog_empty` is 1 when occupancy is at most PEMPTY_TH. The thresholds satisfy 3 <= threshold <= DEPTH-3.
- R11: `prog_full` keeps its value across any cycle in which `full` is 1. `prog_empty` keeps its value across any cycle in which `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| din | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| dout | output | DATA_W | Registered read word |
| data_valid | output | 1 | `dout` carries a word read in the previous cycle |
| full | output | 1 | Buffer holds DEPTH words |
| almost_full | output | 1 | Buffer holds DEPTH-1 words |
| prog_full | output | 1 | Occupancy at or above PFULL_TH |
| empty | output | 1 | Buffer holds no words |
| almost_empty | output | 1 | Buffer holds one word |
| prog_empty | output | 1 | Occupancy at or below PEMPTY_TH |
| overflow | output | 1 | A write was refused in the previous cycle |
| underflow | output | 1 | A read was refused in the previous cycle |
| wr_ack | output | 1 | A write was accepted in the previous cycle |
| occupancy | output | log2(DEPTH)+1 | Number of stored words |

## Verification
The bench fills the buffer to exactly DEPTH words and then keeps writing. A design whose pointers wrap without the extra bit would show the buffer as empty, or would overwrite the oldest word, and the scoreboard would then see the wrong data when the buffer drains. The bench requests reads and writes together while the buffer is full and again while it is empty. A design that gated on the wrong flag would accept the refused side, and the count would come out wrong. The bench also issues reads on an empty buffer and checks that `dout` keeps its value, which exposes an output register that loads on every `rd_en`. A long pseudo-random stretch sweeps the occupancy back and forth across both thresholds and both "almost" points. This catches flags that are off by one or that fire one cycle late.

// File: rtl/sfifo_pkg.sv
// Package: shared types for the synchronous FIFO.
// Assumes nothing beyond the parameters of the top module.
package sfifo_pkg;

    // Outcome of the request pair in one cycle.
    typedef struct packed {
        logic wr_go;   // write accepted at this edge
        logic rd_go;   // read accepted at this edge
        logic wr_rej;  // write requested but refused (full)
        logic rd_rej;  // read requested but refused (empty)
    } fifo_req_t;

endpackage

// File: rtl/sfifo_gate.sv
// Module: sfifo_gate
// Splits each request into accepted or refused, using the flags of the
// current cycle. Purely combinational. Assumes the flags are registered
// outputs, so there is no combinational loop back to the requests.
module sfifo_gate
    import sfifo_pkg::*;
(
    input  logic      wr_en,
    input  logic      rd_en,
    input  logic      full,
    input  logic      empty,
    output fifo_req_t req
);

    // Qualify write and read requests against the present flags.
    always_comb begin
        req.wr_go  = wr_en & ~full;
        req.wr_rej = wr_en &  full;
        req.rd_go  = rd_en & ~empty;
        req.rd_rej = rd_en &  empty;
    end

endmodule

// File: rtl/sfifo_ctrl.sv
// Module: sfifo_ctrl
// Keeps the write and read pointers and derives the occupancy. Registers
// every level flag from the occupancy that follows this edge. The
// pointers carry one extra wrap bit, so that a full buffer and an empty
// buffer do not look alike. Assumes DEPTH is a power of two and that
// 3 <= threshold <= DEPTH-3.
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int PFULL_TH     = 12,
    parameter int PEMPTY_TH    = 4,
    parameter bit FULL_RST_VAL = 1'b0,
    localparam int AW          = $clog2(DEPTH),
    localparam int CW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_req_t     req,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] occupancy,
    output logic          full,
    output logic          almost_full,
    output logic          prog_full,
    output logic          empty,
    output logic          almost_empty,
    output logic          prog_empty
);

    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
    localparam logic [CW-1:0] AFULL_CNT = CW'(DEPTH - 1);
    localparam logic [CW-1:0] PF_CNT    = CW'(PFULL_TH);
    localparam logic [CW-1:0] PE_CNT    = CW'(PEMPTY_TH);

    logic [CW-1:0] wptr, rptr;
    logic [CW-1:0] cnt_nxt;

    assign waddr     = wptr[AW-1:0];
    assign raddr     = rptr[AW-1:0];
    assign occupancy = wptr - rptr;

    // Occupancy after this edge, from the accepted operations.
    always_comb begin
        cnt_nxt = occupancy + CW'(req.wr_go) - CW'(req.rd_go);
    end

    // Advance the pointers on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (req.wr_go) wptr <= wptr + 1'b1;
            if (req.rd_go) rptr <= rptr + 1'b1;
        end
    end

    // Register the full-side flags. prog_full holds while full is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full        <= FULL_RST_VAL;
            almost_full <= FULL_RST_VAL;
            prog_full   <= FULL_RST_VAL;
        end else begin
            full        <= (cnt_nxt == FULL_CNT);
            almost_full <= (cnt_nxt == AFULL_CNT);
            if (!full) prog_full <= (cnt_nxt >= PF_CNT);
        end
    end

    // Register the empty-side flags. prog_empty holds while empty is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty        <= 1'b1;
            almost_empty <= 1'b0;
            prog_empty   <= 1'b1;
        end else begin
            empty        <= (cnt_nxt == '0);
            almost_empty <= (cnt_nxt == CW'(1));
            if (!empty) prog_empty <= (cnt_nxt <= PE_CNT);
        end
    end

endmodule

// File: rtl/sfifo_store.sv
// Module: sfifo_store
// Holds the words and the single read output register. The storage has
// no reset. Only the output register and the valid bit are reset. Assumes
// the read and write addresses come from sfifo_ctrl and name a stored
// word whenever rd_go is high.
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int              DATA_W       = 16,
    parameter int              DEPTH        = 16,
    parameter logic [DATA_W-1:0] DOUT_RST_VAL = '0,
    localparam int             AW           = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fifo_req_t         req,
    input  logic [AW-1:0]     waddr,
    input  logic [AW-1:0]     raddr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              data_valid
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted write.
    always_ff @(posedge clk) begin
        if (req.wr_go) mem[waddr] <= din;
    end

    // Load the output register on an accepted read, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= DOUT_RST_VAL;
            data_valid <= 1'b0;
        end else begin
            data_valid <= req.rd_go;
            if (req.rd_go) dout <= mem[raddr];
        end
    end

endmodule

// File: rtl/sfifo_report.sv
// Module: sfifo_report
// Turns the request outcome of one cycle into one-cycle pulses in the
// next cycle: write accepted, write refused, read refused.
module sfifo_report
    import sfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fifo_req_t req,
    output logic      wr_ack,
    output logic      overflow,
    output logic      underflow
);

    // Register the request outcome as next-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack    <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            wr_ack    <= req.wr_go;
            overflow  <= req.wr_rej;
            underflow <= req.rd_rej;
        end
    end

endmodule

// File: rtl/sfifo_flags.sv
// Module: sfifo_flags (top)
// A single-clock FIFO with standard registered reads and a full set of
// status flags. Assumes DEPTH is a power of two, 3 <= PFULL_TH <= DEPTH-3,
// 3 <= PEMPTY_TH <= DEPTH-3, and that the requests are held low during
// reset.
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter int                DEPTH        = 16,
    parameter int                PFULL_TH     = 12,
    parameter int                PEMPTY_TH    = 4,
    parameter bit                FULL_RST_VAL = 1'b0,
    parameter logic [DATA_W-1:0] DOUT_RST_VAL = '0,
    localparam int               AW           = $clog2(DEPTH),
    localparam int               CW           = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic              data_valid,
    output logic              full,
    output logic              almost_full,
    output logic              prog_full,
    output logic              empty,
    output logic              almost_empty,
    output logic              prog_empty,
    output logic              overflow,
    output logic              underflow,
    output logic              wr_ack,
    output logic [CW-1:0]     occupancy
);

    fifo_req_t     req;
    logic [AW-1:0] waddr, raddr;

    sfifo_gate u_gate (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .full  (full),
        .empty (empty),
        .req   (req)
    );

    sfifo_ctrl #(
        .DEPTH        (DEPTH),
        .PFULL_TH     (PFULL_TH),
        .PEMPTY_TH    (PEMPTY_TH),
        .FULL_RST_VAL (FULL_RST_VAL)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .waddr        (waddr),
        .raddr        (raddr),
        .occupancy    (occupancy),
        .full         (full),
        .almost_full  (almost_full),
        .prog_full    (prog_full),
        .empty        (empty),
        .almost_empty (almost_empty),
        .prog_empty   (prog_empty)
    );

    sfifo_store #(
        .DATA_W       (DATA_W),
        .DEPTH        (DEPTH),
        .DOUT_RST_VAL (DOUT_RST_VAL)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .waddr      (waddr),
        .raddr      (raddr),
        .din        (din),
        .dout       (dout),
        .data_valid (data_valid)
    );

    sfifo_report u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr_ack    (wr_ack),
        .overflow  (overflow),
        .underflow (underflow)
    );

endmodule

// File: rtl/sfifo_flags_chk.sv
// Module: sfifo_flags_chk
// Checker bound to sfifo_flags. It relates the requests at the ports to
// the flags and pulses one cycle later. It assumes the same DEPTH as the
// top.
module sfifo_flags_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic          prog_full,
    input logic          prog_empty,
    input logic          overflow,
    input logic          underflow,
    input logic          wr_ack,
    input logic          data_valid,
    input logic [CW-1:0] occupancy
);

    p_refused_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (overflow && full && occupancy == $past(occupancy)));

    p_refused_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (underflow && empty && occupancy == $past(occupancy)));

    p_write_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> wr_ack);

    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> data_valid);

    p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !(rd_en && !empty)) |=> (occupancy == $past(occupancy) + CW'(1)));

    p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && rd_en && !empty) |=> $stable(occupancy));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_pfull_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(prog_full));

    p_pempty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> $stable(prog_empty));

endmodule

bind sfifo_flags sfifo_flags_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .full       (full),
    .empty      (empty),
    .prog_full  (prog_full),
    .prog_empty (prog_empty),
    .overflow   (overflow),
    .underflow  (underflow),
    .wr_ack     (wr_ack),
    .data_valid (data_valid),
    .occupancy  (occupancy)
);

// File: tb/sfifo_flags_test.sv
// Bench for sfifo_flags. A driver task drives one request pair per cycle.
// It pushes each accepted word into a scoreboard queue and checks the
// flags against a count model. A monitor process pops the queue and
// compares each word that appears with data_valid.
module sfifo_flags_test;

    localparam int DW   = 16;
    localparam int D    = 16;
    localparam int PF   = 12;
    localparam int PE   = 4;
    localparam int CW   = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          data_valid, full, almost_full, prog_full;
    logic          empty, almost_empty, prog_empty;
    logic          overflow, underflow, wr_ack;
    logic [CW-1:0] occupancy;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;
    bit live   = 1'b0;
    logic [DW-1:0] sb_q[$];
    logic [DW-1:0] last_dout = '0;

    sfifo_flags #(.DATA_W(DW), .DEPTH(D), .PFULL_TH(PF), .PEMPTY_TH(PE)) uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .din (din), .rd_en (rd_en),
        .dout (dout), .data_valid (data_valid), .full (full),
        .almost_full (almost_full), .prog_full (prog_full), .empty (empty),
        .almost_empty (almost_empty), .prog_empty (prog_empty),
        .overflow (overflow), .underflow (underflow), .wr_ack (wr_ack),
        .occupancy (occupancy)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Check every level flag against the model count.
    task automatic check_levels();
        check("R7", "occupancy", 32'(occupancy), 32'(mcnt));
        check("R8", "full", 32'(full), 32'(mcnt == D));
        check("R8", "empty", 32'(empty), 32'(mcnt == 0));
        check("R9", "almost_full", 32'(almost_full), 32'(mcnt == D - 1));
        check("R9", "almost_empty", 32'(almost_empty), 32'(mcnt == 1));
        check("R10", "prog_full", 32'(prog_full), 32'(mcnt >= PF));
        check("R10", "prog_empty", 32'(prog_empty), 32'(mcnt <= PE));
    endtask

    // Drive one request pair for one cycle, then check the results.
    task automatic step(input bit we, input bit re, input logic [DW-1:0] d);
        bit aw, ar;
        aw = we && (mcnt < D);
        ar = re && (mcnt > 0);
        wr_en = we; rd_en = re; din = d;
        if (aw) sb_q.push_back(d);
        @(posedge clk);
        @(negedge clk);
        mcnt = mcnt + int'(aw) - int'(ar);
        check("R5", "wr_ack", 32'(wr_ack), 32'(aw));
        check("R3", "overflow", 32'(overflow), 32'(we && !aw));
        check("R4", "underflow", 32'(underflow), 32'(re && !ar));
        check("R6", "data_valid", 32'(data_valid), 32'(ar));
        check_levels();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Monitor: compare each word read against the scoreboard. R2 R6
    always @(negedge clk) begin
        if (live) begin
            if (data_valid) begin
                if (sb_q.size() == 0) begin
                    check("R2", "unexpected read word", 32'(dout), 32'hFFFF_FFFF);
                end else begin
                    check("R2", "read order", 32'(dout), 32'(sb_q.pop_front()));
                end
            end else begin
                check("R6", "dout hold", 32'(dout), 32'(last_dout));
            end
            last_dout = dout;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "dout reset", 32'(dout), 32'h0);
        check("R1", "data_valid reset", 32'(data_valid), 32'h0);
        check("R1", "pulses reset", 32'({overflow, underflow, wr_ack}), 32'h0);
        check("R1", "almost_full reset", 32'(almost_full), 32'h0);
        check_levels();
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);

        // R4: read while empty has no effect
        step(1'b0, 1'b1, 16'h0);
        // R2 R6: single word through
        step(1'b1, 1'b0, 16'hA5A5);
        step(1'b0, 1'b1, 16'h0);
        // Fill to exactly D words (R8 R9 R10)
        for (int i = 0; i < D; i++) step(1'b1, 1'b0, 16'(16'h1000 + i));
        // R3: write while full is refused
        step(1'b1, 1'b0, 16'hDEAD);
        step(1'b1, 1'b0, 16'hBEEF);
        // R11 R2: write and read together while full: only the read is accepted
        step(1'b1, 1'b1, 16'hCAFE);
        // R7: both accepted at D-1, count unchanged
        step(1'b1, 1'b1, 16'h2222);
        step(1'b1, 1'b1, 16'h3333);
        // Drain completely
        for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1, 16'h0);
        // R4 R2: read and write together while empty: only the write is accepted
        step(1'b1, 1'b1, 16'h4444);
        step(1'b0, 1'b1, 16'h0);
        // Mixed pseudo-random traffic across both thresholds
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            bit bias;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bias = (i / 60) % 2 == 0;
            step(bias ? (lfsr[1:0] != 2'b00) : (lfsr[1:0] == 2'b00),
                 bias ? (lfsr[3:2] == 2'b00) : (lfsr[3:2] != 2'b00),
                 lfsr ^ 16'(i));
        end
        for (int i = 0; i < D + 1; i++) step(1'b0, 1'b1, 16'h0);
        check("R2", "scoreboard drained", 32'(sb_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule